// File: doc/BRIEF.md
# Command-Driven Sample Streamer

This block connects the result port of a data converter to a byte-wide serial transmitter and receiver. Each end-of-conversion strobe latches the result as the latest sample. Single ASCII characters arriving from the receiver select one of four actions, and upper and lower case mean the same thing. One action sends the latest sample once. Two actions turn continuous streaming on and off; while streaming, every new conversion is sent as it completes. The fourth action sends the next value of an incrementing test counter, which lets the link be checked without converter data.

Each reply is one byte, because samples are 8 bits wide. Outgoing bytes pass through a single pending slot with a valid/ready handshake toward the serializer. A request that arrives while the serializer is busy replaces any byte that has not been sent yet. The serializer is expected to run at 115200 baud, 8 data bits, no parity, one stop bit and no flow control. The serializer, the deserializer and the converter are outside the block.

Top module: `smp_streamer`

## Requirements
- R1: A cycle with `conv_done` high stores `conv_data` as the latest sample, ready for the next cycle; after reset the latest sample is 0x00.
- R2: A received byte 0x43 or 0x63 ('C'/'c') places the latest sample held in that cycle into the pending slot; `tx_valid` is high with that byte in the next cycle.
- R3: A received byte 0x53 or 0x73 ('S'/'s') turns streaming on. While streaming, a cycle with `conv_done` high places that cycle's `conv_data` into the pending slot.
- R4: A received byte 0x58 or 0x78 ('X'/'x') turns streaming off; later conversions are not sent.
- R5: A received byte 0x45 or 0x65 ('E'/'e') places the test counter value into the pending slot and advances the counter by exactly 1. The counter starts at 0 after reset and wraps from 255 to 0.
- R6: Any other received byte starts no transmission, leaves the streaming mode unchanged and leaves the test counter unchanged.
- R7: Only one byte is pending at a time. While `tx_valid` is high and `tx_ready` is low, `tx_data` holds steady unless a new request arrives; a new request overwrites the unsent byte. The byte is removed in the cycle after `tx_valid` and `tx_ready` are both high.
- R8: A 'C' or 'E' request received while streaming is served, and streaming stays on.
- R9: After reset, `tx_valid` is low and streaming is off.
- R10: When a command reply and a streamed conversion fall in the same cycle, the command reply takes the slot and the streamed conversion is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_data | input | 8 | Converter result |
| conv_done | input | 1 | End-of-conversion strobe, one cycle |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | Received character is valid this cycle |
| tx_data | output | 8 | Byte offered to the serializer |
| tx_valid | output | 1 | A byte is pending |
| tx_ready | input | 1 | Serializer accepts the pending byte |

## Verification
The assertions assume that `rx_valid` and `conv_done` are single-cycle strobes, sampled on the rising edge, and that both are low during reset. The stimulus changes inputs only on the falling edge and drops each strobe after exactly one cycle. The one exception is a deliberate case where a character and a conversion share a cycle, to exercise the priority rule. `tx_ready` stays high except in the back-pressure scenario, where it is held low across several cycles so that both holding and overwriting can be seen.

// File: rtl/smp_pkg.sv
package smp_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ONCE,
        CMD_STREAM,
        CMD_STOP,
        CMD_EMU
    } cmd_e;

    localparam logic [7:0] CH_ONCE   = 8'h43;
    localparam logic [7:0] CH_STREAM = 8'h53;
    localparam logic [7:0] CH_STOP   = 8'h58;
    localparam logic [7:0] CH_EMU    = 8'h45;
    localparam logic [7:0] CASE_BIT  = 8'h20;

endpackage

// File: rtl/smp_cmd_decode.sv
module smp_cmd_decode
    import smp_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_valid,
    output cmd_e              cmd
);

    localparam logic [CHAR_W-1:0] LOW_A = CHAR_W'(8'h61);
    localparam logic [CHAR_W-1:0] LOW_Z = CHAR_W'(8'h7A);

    logic [CHAR_W-1:0] folded;

    always_comb begin
        if (rx_data >= LOW_A && rx_data <= LOW_Z) begin
            folded = rx_data & ~CHAR_W'(CASE_BIT);
        end else begin
            folded = rx_data;
        end
    end

    always_comb begin
        cmd = CMD_NONE;
        if (rx_valid) begin
            unique case (folded)
                CHAR_W'(CH_ONCE):   cmd = CMD_ONCE;
                CHAR_W'(CH_STREAM): cmd = CMD_STREAM;
                CHAR_W'(CH_STOP):   cmd = CMD_STOP;
                CHAR_W'(CH_EMU):    cmd = CMD_EMU;
                default:            cmd = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/smp_sample_hold.sv
module smp_sample_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] latest
);

    typedef struct packed {
        logic [DATA_W-1:0] value;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (capture) begin
            hold_d.value = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign latest = hold_q.value;

endmodule

// File: rtl/smp_test_counter.sv
module smp_test_counter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [DATA_W-1:0] value
);

    localparam logic [DATA_W-1:0] STEP = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] count;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (advance) begin
            cnt_d.count = cnt_q.count + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign value = cnt_q.count;

endmodule

// File: rtl/smp_tx_slot.sv
module smp_tx_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.full && tx_ready) begin
            slot_d.full = 1'b0;
        end
        if (load) begin
            slot_d.full = 1'b1;
            slot_d.data = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign tx_valid = slot_q.full;
    assign tx_data  = slot_q.data;

endmodule

// File: rtl/smp_streamer.sv
module smp_streamer
    import smp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              conv_done,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready
);

    typedef struct packed {
        logic streaming;
    } mode_t;

    mode_t             mode_d, mode_q;
    cmd_e              cmd;
    logic [DATA_W-1:0] latest;
    logic [DATA_W-1:0] emu_value;
    logic              emu_adv;
    logic              req_load;
    logic [DATA_W-1:0] req_data;

    smp_cmd_decode #(.CHAR_W(CHAR_W)) decode_i (
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .cmd      (cmd)
    );

    smp_sample_hold #(.DATA_W(DATA_W)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (conv_done),
        .din     (conv_data),
        .latest  (latest)
    );

    smp_test_counter #(.DATA_W(DATA_W)) emu_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (emu_adv),
        .value   (emu_value)
    );

    smp_tx_slot #(.DATA_W(DATA_W)) slot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (req_load),
        .load_data (req_data),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    // Mode state and request arbitration: a command reply outranks a streamed result.
    always_comb begin
        mode_d   = mode_q;
        emu_adv  = 1'b0;
        req_load = 1'b0;
        req_data = '0;
        unique case (cmd)
            CMD_STREAM: mode_d.streaming = 1'b1;
            CMD_STOP:   mode_d.streaming = 1'b0;
            default:    mode_d = mode_q;
        endcase
        if (cmd == CMD_ONCE) begin
            req_load = 1'b1;
            req_data = latest;
        end else if (cmd == CMD_EMU) begin
            req_load = 1'b1;
            req_data = emu_value;
            emu_adv  = 1'b1;
        end else if (mode_q.streaming && conv_done) begin
            req_load = 1'b1;
            req_data = conv_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/smp_streamer_chk.sv
module smp_streamer_chk
    import smp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] conv_data,
    input logic              conv_done,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              streaming,
    input logic              req_load,
    input logic [DATA_W-1:0] latest,
    input logic [DATA_W-1:0] emu_value,
    input cmd_e              cmd
);

    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> latest == $past(conv_data));

    a_r3_stream_send: assert property (@(posedge clk) disable iff (!rst_n)
        (streaming && conv_done && cmd != CMD_ONCE && cmd != CMD_EMU)
        |=> tx_valid && tx_data == $past(conv_data));

    a_r4_stop: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_STOP |=> !streaming);

    a_r5_emu_step: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_EMU |=> emu_value == DATA_W'($past(emu_value) + 1'b1));

    a_r6_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NONE) |=> streaming == $past(streaming));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !req_load) |=> tx_valid && $stable(tx_data));

    a_r7_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !req_load) |=> !tx_valid);

    a_r8_keep_stream: assert property (@(posedge clk) disable iff (!rst_n)
        (streaming && (cmd == CMD_ONCE || cmd == CMD_EMU)) |=> streaming);

endmodule

bind smp_streamer smp_streamer_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_data (conv_data),
    .conv_done (conv_done),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .streaming (mode_q.streaming),
    .req_load  (req_load),
    .latest    (latest),
    .emu_value (emu_value),
    .cmd       (cmd)
);

// File: tb/smp_streamer_tb_top.sv
module smp_streamer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] conv_data = '0;
    logic       conv_done = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b1;

    int         n_checks = 0;
    int         n_errors = 0;
    logic [7:0] emu_exp = 8'h00;

    always #5 clk = ~clk;

    smp_streamer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_data (conv_data),
        .conv_done (conv_done),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Character held for one cycle; returns at the falling edge after it was sampled.
    task automatic send(logic [7:0] ch);
        @(negedge clk);
        rx_data  = ch;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic conv(logic [7:0] v);
        @(negedge clk);
        conv_data = v;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic t_reset;
        check("R9 tx_valid after reset", 16'(tx_valid), 16'h0);
        conv(8'h66);
        check("R9 not streaming after reset", 16'(tx_valid), 16'h0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        send("C");
        check("R2 reply valid", 16'(tx_valid), 16'h1);
        check("R1 sample zero after reset", 16'(tx_data), 16'h00);
    endtask

    task automatic t_oneshot;
        conv(8'h5A);
        check("R1 no send while idle", 16'(tx_valid), 16'h0);
        send("c");
        check("R2 lower c valid", 16'(tx_valid), 16'h1);
        check("R1 latched sample", 16'(tx_data), 16'h5A);
        conv(8'hA7);
        send("C");
        check("R2 upper C data", 16'(tx_data), 16'hA7);
    endtask

    task automatic t_ignore;
        send("Q");
        check("R6 Q no send", 16'(tx_valid), 16'h0);
        send(8'h00);
        check("R6 NUL no send", 16'(tx_valid), 16'h0);
        conv(8'h11);
        check("R6 mode not changed", 16'(tx_valid), 16'h0);
        send("e");
        check("R6 counter untouched", 16'(tx_data), 16'(emu_exp));
        emu_exp++;
    endtask

    task automatic t_stream;
        send("s");
        check("R3 enter sends nothing", 16'(tx_valid), 16'h0);
        conv(8'h21);
        check("R3 stream valid", 16'(tx_valid), 16'h1);
        check("R3 stream data 1", 16'(tx_data), 16'h21);
        conv(8'h22);
        check("R3 stream data 2", 16'(tx_data), 16'h22);
        send("Q");
        check("R6 ignored while streaming", 16'(tx_valid), 16'h0);
        conv(8'h23);
        check("R6 still streaming", 16'(tx_data), 16'h23);
        send("C");
        check("R8 one-shot in stream", 16'(tx_data), 16'h23);
        send("E");
        check("R8 emu in stream", 16'(tx_data), 16'(emu_exp));
        emu_exp++;
        conv(8'h24);
        check("R8 stream kept valid", 16'(tx_valid), 16'h1);
        check("R8 stream kept data", 16'(tx_data), 16'h24);
        @(negedge clk);
        rx_data   = "C";
        rx_valid  = 1'b1;
        conv_data = 8'h30;
        conv_done = 1'b1;
        @(negedge clk);
        rx_valid  = 1'b0;
        conv_done = 1'b0;
        check("R10 reply wins", 16'(tx_data), 16'h24);
        @(negedge clk);
        check("R10 stream byte dropped", 16'(tx_valid), 16'h0);
        send("x");
        check("R4 stop sends nothing", 16'(tx_valid), 16'h0);
        conv(8'h31);
        check("R4 no stream after x", 16'(tx_valid), 16'h0);
        send("S");
        send("X");
        conv(8'h32);
        check("R4 no stream after X", 16'(tx_valid), 16'h0);
    endtask

    task automatic t_emu;
        for (int i = 0; i < 260; i++) begin
            send((i % 2 == 0) ? "E" : "e");
            check("R5 emu value", 16'(tx_data), 16'(emu_exp));
            emu_exp++;
        end
    endtask

    task automatic t_backpressure;
        logic [7:0] first;
        @(negedge clk);
        tx_ready = 1'b0;
        first = emu_exp;
        send("E");
        emu_exp++;
        check("R7 pending valid", 16'(tx_valid), 16'h1);
        repeat (3) @(negedge clk);
        check("R7 held valid", 16'(tx_valid), 16'h1);
        check("R7 held data", 16'(tx_data), 16'(first));
        conv(8'h40);
        check("R7 held after conv", 16'(tx_data), 16'(first));
        send("C");
        check("R7 overwrite", 16'(tx_data), 16'h40);
        tx_ready = 1'b1;
        @(negedge clk);
        check("R7 drained", 16'(tx_valid), 16'h0);
        send("E");
        check("R5 counter advanced despite overwrite", 16'(tx_data), 16'(emu_exp));
        emu_exp++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot();
        t_ignore();
        t_stream();
        t_emu();
        t_backpressure();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule